// File: doc/BRIEF.md
# Buffered PWM Output Channel

This block is one timer channel that produces a pulse-width and frequency modulated output. A count register runs upward from 1 to the value held in the period register and then restarts at 1. An edge register sets the count at which the output falls back to its passive level. A two-stage clock-enable divider sets the count rate. The first stage is global and the second is local to the channel.

Software never writes the live period and edge registers directly. It writes two shadow registers. Their contents move into the live pair together, in the last system clock of a count cycle, which is the same clock that reloads the count with 1. An update-hold input can defer this transfer so that several channels change in step. An edge value of 0 gives a clean 0% duty. Its match is taken at count 1, and it overrides the period-start transition that lands on the same clock.

The output level is held by a two-state machine with the states LVL_PASSIVE and LVL_DRIVE. The transition "period start" goes from LVL_PASSIVE to LVL_DRIVE when the count wraps and no edge match is present. The transition "edge match" goes from LVL_DRIVE to LVL_PASSIVE. The pin shows the state XOR the polarity input. A sticky event flag reports period ends, and edge matches as well when it is selected.

Top module: `pwmb_chan`

## Requirements
- R1: The internal count resets to 1 and advances by one per count tick. On the tick where the count is at least the live period value, it reloads to 1 (the wrap). It never holds 0. A period value of P gives an output period of P count ticks.
- R2: A count tick occurs when both divider stages expire together. The global stage expires every `glb_div`+1 clocks, and the channel stage expires every `chn_div`+1 global expiries. With both at 1, the count advances once every 4 clocks.
- R3: A one-clock `wr_edge` pulse loads `wr_data` into the edge shadow register, and a `wr_period` pulse loads it into the period shadow register. On a wrap with the hold input low, both shadow values are copied into the live registers in that same clock, so they govern the next count cycle.
- R4: While `upd_hold` is 1 on a wrap, the live registers keep their values. The output duty therefore stays unchanged until a wrap occurs with the hold input low.
- R5: Let the live edge value be E, with 1 ≤ E < P. The output is in LVL_DRIVE during counts 1..E and in LVL_PASSIVE during counts E+1..P, which gives E of P ticks active. When E ≥ P, no edge match leaves the period, so the duty is 100%.
- R6: An edge value of 0 (the incoming value at the wrap) produces an edge match on the wrap tick itself. This match takes priority over the period start, so the output stays passive for the whole cycle and gives 0% duty.
- R7: `pwm_out` equals (state is LVL_DRIVE) XOR `pol_inv`. With `pol_inv`=0 the active level is high, and with `pol_inv`=1 it is low.
- R8: With `flag_any`=0, the flag is set only on a wrap. With `flag_any`=1, the flag is set on a wrap or on an edge match.
- R9: The flag is sticky. A `flag_clr` pulse clears it, but a flag event in the same clock wins and the flag stays set.
- R10: Reset leaves the flag at 0, the state at LVL_PASSIVE (so the pin shows the passive level), the count at 1, and all four value registers at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_div | input | PRE_W | Global divider setting (ratio = value+1) |
| chn_div | input | PRE_W | Channel divider setting (ratio = value+1) |
| wr_edge | input | 1 | Write strobe for the edge shadow register |
| wr_period | input | 1 | Write strobe for the period shadow register |
| wr_data | input | CNT_W | Data for the shadow register writes |
| upd_hold | input | 1 | Holds the shadow-to-live transfer at a wrap |
| pol_inv | input | 1 | Output polarity select |
| flag_any | input | 1 | Flag on edge matches as well as wraps |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| flag | output | 1 | Sticky event flag |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench attacks the edge value of 0. A design that takes this match on the wrong side of count 1, or that lets the period start win, shows one-clock glitches where the output should sit at 0%. It attacks the reload boundary in two ways. It writes shadow values while the hold input is high, where a leaky transfer changes the duty early. It also writes them right next to a wrap, where an off-by-one load makes the new duty appear one cycle late or early. Other targets are the divider pair at ratios above one, which a swapped or single-stage divider gets wrong, and the flag clear landing on the same clock as a flag event.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
    typedef enum logic {
        LVL_PASSIVE = 1'b0,
        LVL_DRIVE   = 1'b1
    } lvl_e;
endpackage

// File: rtl/pwmb_prescale.sv
module pwmb_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] glb_div,
    input  logic [PRE_W-1:0] chn_div,
    output logic             tick
);
    localparam int NSTAGE = 2;

    logic [NSTAGE-1:0][PRE_W-1:0] div;
    logic [NSTAGE:0]              en;

    assign div[0] = glb_div;
    assign div[1] = chn_div;
    assign en[0]  = 1'b1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        logic [PRE_W-1:0] q;
        logic             expire;
        assign expire = (q >= div[s]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (en[s])
                q <= expire ? '0 : q + 1'b1;
        end
        assign en[s+1] = en[s] && expire;
    end

    assign tick = en[NSTAGE];
endmodule

// File: rtl/pwmb_timebase.sv
module pwmb_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_edge,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd_hold,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] edge_nxt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, edge_sh, per_sh, edge_q, per_q;
    logic             load;

    assign wrap     = tick && (cnt_q >= per_q);
    assign load     = wrap && !upd_hold;
    assign edge_nxt = load ? edge_sh : edge_q;
    assign cnt      = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= ONE;
        else if (tick)
            cnt_q <= wrap ? ONE : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_sh <= '0;
            per_sh  <= '0;
        end else begin
            if (wr_edge)   edge_sh <= wr_data;
            if (wr_period) per_sh  <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            per_q  <= '0;
        end else if (load) begin
            edge_q <= edge_sh;
            per_q  <= per_sh;
        end
    end

    // R1
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);
    // R1
    reload_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == ONE));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !upd_hold) |=> (edge_q == $past(edge_sh) && per_q == $past(per_sh)));
    // R4
    hold_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && upd_hold) |=> ($stable(edge_q) && $stable(per_q)));
endmodule

// File: rtl/pwmb_wave.sv
module pwmb_wave
    import pwmb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] edge_nxt,
    input  logic             pol_inv,
    input  logic             flag_any,
    input  logic             flag_clr,
    output logic             flag,
    output logic             pwm_out
);
    lvl_e state_q, state_d;
    logic a_ev, b_ev, flag_set, flag_q;

    // zero edge: match on the wrap (count becomes 1); otherwise on leaving count E
    assign a_ev = tick && ((edge_nxt == '0) ? wrap : (!wrap && cnt == edge_nxt));
    assign b_ev = wrap;
    assign flag_set = b_ev || (flag_any && a_ev);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_PASSIVE: if (b_ev && !a_ev) state_d = LVL_DRIVE;
            LVL_DRIVE:   if (a_ev)          state_d = LVL_PASSIVE;
            default:                        state_d = LVL_PASSIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LVL_PASSIVE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (flag_set)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    always_comb begin
        pwm_out = (state_q == LVL_DRIVE) ^ pol_inv;
        flag    = flag_q;
    end

    // R5
    edge_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ev |=> (state_q == LVL_PASSIVE));
    // R6
    zero_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && edge_nxt == '0) |=> (state_q == LVL_PASSIVE));
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag_q);
    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !flag_set) |=> !flag_q);
endmodule

// File: rtl/pwmb_chan.sv
module pwmb_chan #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] glb_div,
    input  logic [PRE_W-1:0] chn_div,
    input  logic             wr_edge,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd_hold,
    input  logic             pol_inv,
    input  logic             flag_any,
    input  logic             flag_clr,
    output logic             flag,
    output logic             pwm_out
);
    logic             tick, wrap;
    logic [CNT_W-1:0] cnt, edge_nxt;

    pwmb_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .glb_div(glb_div), .chn_div(chn_div), .tick(tick)
    );

    pwmb_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_edge(wr_edge),
        .wr_period(wr_period), .wr_data(wr_data), .upd_hold(upd_hold),
        .cnt(cnt), .edge_nxt(edge_nxt), .wrap(wrap)
    );

    pwmb_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt),
        .edge_nxt(edge_nxt), .pol_inv(pol_inv), .flag_any(flag_any),
        .flag_clr(flag_clr), .flag(flag), .pwm_out(pwm_out)
    );
endmodule

// File: tb/pwmb_chan_tb.sv
module pwmb_chan_tb;
    localparam int CNT_W = 16;
    localparam int PRE_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PRE_W-1:0] glb_div = '0, chn_div = '0;
    logic             wr_edge = 1'b0, wr_period = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             upd_hold = 1'b0, pol_inv = 1'b0, flag_any = 1'b0, flag_clr = 1'b0;
    logic             flag, pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected-value state
    int m_g, m_c, m_cnt, m_e2, m_p2, m_e1, m_p1;
    bit m_lvl, m_flag;

    always #10 clk = ~clk;

    pwmb_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .glb_div(glb_div), .chn_div(chn_div),
        .wr_edge(wr_edge), .wr_period(wr_period), .wr_data(wr_data),
        .upd_hold(upd_hold), .pol_inv(pol_inv), .flag_any(flag_any),
        .flag_clr(flag_clr), .flag(flag), .pwm_out(pwm_out)
    );

    function automatic bit exp_pwm();
        return m_lvl ^ pol_inv;
    endfunction

    task automatic model_reset();
        m_g = 0; m_c = 0; m_cnt = 1;
        m_e2 = 0; m_p2 = 0; m_e1 = 0; m_p1 = 0;
        m_lvl = 1'b0; m_flag = 1'b0;
    endtask

    // one clock of behaviour, per the requirements, with the current inputs
    task automatic model_step();
        bit gt, ct, wr, ld, aev, setf;
        int e_n;
        gt = (m_g >= int'(glb_div));
        ct = gt && (m_c >= int'(chn_div));
        wr = ct && (m_cnt >= m_p1);
        ld = wr && !upd_hold;
        e_n = ld ? m_e2 : m_e1;
        aev = ct && ((e_n == 0) ? wr : (!wr && m_cnt == e_n));
        setf = wr || (flag_any && aev);
        if (aev) m_lvl = 1'b0;
        else if (wr) m_lvl = 1'b1;
        if (setf) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
        if (ld) begin m_e1 = m_e2; m_p1 = m_p2; end
        if (ct) m_cnt = wr ? 1 : (m_cnt + 1) % (1 << CNT_W);
        if (gt) m_c = ct ? 0 : m_c + 1;
        m_g = gt ? 0 : m_g + 1;
        if (wr_edge)   m_e2 = int'(wr_data);
        if (wr_period) m_p2 = int'(wr_data);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // apply current inputs for one clock and compare at the next falling edge
    task automatic run(input string req);
        model_step();
        @(negedge clk);
        check(req, "pwm_out", int'(pwm_out), int'(exp_pwm()));
        check(req, "flag", int'(flag), int'(m_flag));
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) run(req);
    endtask

    task automatic wr_reg(input bit is_edge, input int val, input string req);
        wr_data = CNT_W'(val);
        if (is_edge) wr_edge = 1'b1; else wr_period = 1'b1;
        run(req);
        wr_edge = 1'b0; wr_period = 1'b0;
    endtask

    task automatic count_high(input string req, input int n, input int exp_high);
        int h;
        h = 0;
        for (int i = 0; i < n; i++) begin
            run(req);
            if (pwm_out) h++;
        end
        check(req, "active clocks in window", h, exp_high);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "pwm_out at reset", int'(pwm_out), 0);
        check("R10", "flag at reset", int'(flag), 0);
        rst_n = 1'b1;
        idle("R10", 4);

        // R5 duty E=2 of P=4
        wr_reg(0, 4, "R3"); wr_reg(1, 2, "R3");
        idle("R3", 12);
        count_high("R5", 8, 4);
        // R6 zero edge -> 0%
        wr_reg(1, 0, "R6"); idle("R6", 12);
        count_high("R6", 16, 0);
        // R5 edge beyond period -> 100%
        wr_reg(1, 5, "R5"); idle("R5", 12);
        count_high("R5", 8, 8);
        // R1 period of 3 ticks, edge 1
        wr_reg(0, 3, "R1"); wr_reg(1, 1, "R1"); idle("R1", 12);
        count_high("R1", 6, 2);
        // R4 hold keeps live values
        upd_hold = 1'b1;
        wr_reg(1, 0, "R4"); idle("R4", 12);
        count_high("R4", 6, 2);
        upd_hold = 1'b0; idle("R4", 12);
        count_high("R4", 6, 0);
        // R2 both dividers at 1: period 2 ticks * 4 clocks
        glb_div = 8'd1; chn_div = 8'd1;
        wr_reg(0, 2, "R2"); wr_reg(1, 1, "R2"); idle("R2", 40);
        count_high("R2", 16, 8);
        // R7 polarity, E=1 of P=4 undivided
        glb_div = '0; chn_div = '0;
        wr_reg(0, 4, "R7"); idle("R7", 12);
        count_high("R7", 8, 2);
        pol_inv = 1'b1;
        count_high("R7", 8, 6);
        pol_inv = 1'b0;
        // R8 flag modes, R9 clear
        flag_clr = 1'b1; run("R9"); flag_clr = 1'b0;
        idle("R8", 8);
        flag_any = 1'b1;
        for (int i = 0; i < 16; i++) begin
            flag_clr = (i % 3 == 0); run("R8");
        end
        flag_clr = 1'b0; flag_any = 1'b0;
        // R9 set wins over clear: period 1 wraps every clock
        wr_reg(0, 1, "R9"); idle("R9", 8);
        flag_clr = 1'b1; run("R9");
        check("R9", "flag set beats clear", int'(flag), 1);
        flag_clr = 1'b0;

        // random mix
        for (int i = 0; i < 6000; i++) begin
            glb_div  = ($urandom % 8 == 0) ? PRE_W'($urandom % 3) : glb_div;
            chn_div  = ($urandom % 8 == 0) ? PRE_W'($urandom % 3) : chn_div;
            wr_data  = CNT_W'($urandom % 8);
            wr_edge  = ($urandom % 10 == 0);
            wr_period = !wr_edge && ($urandom % 12 == 0);
            upd_hold = ($urandom % 5 == 0);
            flag_any = ($urandom % 4 == 0) ? ~flag_any : flag_any;
            pol_inv  = ($urandom % 50 == 0) ? ~pol_inv : pol_inv;
            flag_clr = ($urandom % 6 == 0);
            run("R3");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule